// File: doc/BRIEF.md
# Output-Stationary Systolic Matrix Multiplier

This block computes the product C = A·B of two 3x3 matrices of signed 8-bit integers on a grid of nine multiply-accumulate cells. Each cell owns one entry of C and keeps it in its own accumulator. Operands move through the grid instead: entries of A travel rightward along the rows and entries of B travel downward along the columns, one cell per clock.

A one-cycle start pulse captures both matrices and clears every accumulator. A controller then feeds the left edge of row i and the top edge of column j from the captured copies. Each edge is skewed by its own index, so that a(i,k) and b(k,j) reach cell (i,j) in the same cycle. When no operand is due, an edge is driven with zero. Seven clocks after the start is sampled, the last cell adds its final term and a one-cycle done pulse is raised. The nine 18-bit results then hold until the next accepted start.

Top module: `systolic_mm`

## Requirements
- R1: While reset is high and in the first cycle after it, `done` and `busy` are 0 and every result in `c_flat` is 0.
- R2: After a start, the result for cell (i,j) equals the sum over k of a(i,k)·b(k,j), computed as signed values. Entry (r,c) of `a_flat`, `b_flat` and `c_flat` occupies element slot r*3+c, and each slot is a contiguous field with the lowest slot in the lowest bits.
- R3: `done` is high for exactly one cycle. It appears in the cycle that follows the seventh rising edge after the edge that sampled an accepted start.
- R4: From `done` until the next accepted start, `c_flat` does not change, regardless of any change on `a_flat` or `b_flat`.
- R5: A start pulse that arrives while `busy` is high has no effect. Changes on `a_flat` and `b_flat` after the start edge also have no effect. The final results and the timing of `done` are those of the original start.
- R6: A start is accepted whenever `busy` is low, including the cycle in which `done` is high. Its results do not include any part of the previous product.
- R7: With every input at -128, each result is 49152, and no result wraps.
- R8: Term k of cell (i,j) is added at edge i+j+k+1 after the start edge. After edge m, cell (i,j) therefore holds exactly the sum of the terms with i+j+k+1 <= m. Edges and terms outside this schedule add nothing.
- R9: `busy` is high after start edges 0 through 6 and is low after edge 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to capture the matrices and begin a product |
| a_flat | input | 72 | Matrix A, nine signed 8-bit entries, entry (r,c) in slot r*3+c |
| b_flat | input | 72 | Matrix B, same layout as A |
| c_flat | output | 162 | Product C, nine signed 18-bit entries, same slot layout |
| busy | output | 1 | High while a product is in progress |
| done | output | 1 | One-cycle pulse when the product is complete |

## Verification
Two functions can fall in the same cycle: the completion pulse of one product and the acceptance of the next start. The bench provokes this by raising start in the very cycle that `done` is high. It then checks every intermediate partial sum of the second product against a schedule computed from its own matrices. Any leftover of the first product shows up as a mismatch at the first step. A start raised at step 3 of a running product, together with new data on the matrix inputs, must leave both the results and the `done` timing of that product unchanged.

// File: rtl/mm_pkg.sv
package mm_pkg;
  localparam int MM_N  = 3;
  localparam int MM_DW = 8;
  localparam int MM_AW = 18;

  typedef enum logic {ST_IDLE = 1'b0, ST_RUN = 1'b1} mm_state_e;
endpackage

// File: rtl/mm_ctrl.sv
module mm_ctrl
  import mm_pkg::*;
#(
  parameter int N  = MM_N,
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  output logic          accept,
  output logic          busy,
  output logic          done,
  output logic [CW-1:0] cnt
);
  localparam int LAST = 3 * N - 3;

  mm_state_e state;

  assign accept = start && (state == ST_IDLE);
  assign busy   = (state == ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state <= ST_RUN;
            cnt   <= '0;
          end
        end
        default: begin
          if (cnt == CW'(LAST)) begin
            state <= ST_IDLE;
            done  <= 1'b1;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
      endcase
    end
  end

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_last_step_done_r3: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt == CW'(LAST)) |=> (done && !busy));

  p_start_ignored_r5: assert property (@(posedge clk) disable iff (rst)
    (busy && cnt != CW'(LAST)) |=> (busy && cnt == CW'($past(cnt) + 1'b1)));
endmodule

// File: rtl/mm_feed.sv
module mm_feed #(
  parameter int N    = 3,
  parameter int DW   = 8,
  parameter int CW   = 3,
  parameter int LANE = 0
) (
  input  logic                 busy,
  input  logic [CW-1:0]        cnt,
  input  logic [N*DW-1:0]      vec,
  output logic signed [DW-1:0] feed
);
  always_comb begin
    feed = '0;
    for (int k = 0; k < N; k++) begin
      if (busy && cnt == CW'(LANE + k)) feed = vec[k*DW +: DW];
    end
  end
endmodule

// File: rtl/mm_pe.sv
module mm_pe #(
  parameter int DW = 8,
  parameter int AW = 18
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] a_in,
  input  logic signed [DW-1:0] b_in,
  output logic signed [DW-1:0] a_out,
  output logic signed [DW-1:0] b_out,
  output logic signed [AW-1:0] acc
);
  localparam int PW = 2 * DW;

  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;

  assign prod     = a_in * b_in;
  assign prod_ext = {{(AW-PW){prod[PW-1]}}, prod};

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      a_out <= '0;
      b_out <= '0;
      acc   <= '0;
    end else begin
      a_out <= a_in;
      b_out <= b_in;
      if (en) acc <= acc + prod_ext;
    end
  end

  p_idle_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (!en && !clr) |=> $stable(acc));

  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    clr |=> (acc == '0));
endmodule

// File: rtl/systolic_mm.sv
module systolic_mm
  import mm_pkg::*;
#(
  parameter int N  = MM_N,
  parameter int DW = MM_DW,
  parameter int AW = MM_AW
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [N*N*DW-1:0] a_flat,
  input  logic [N*N*DW-1:0] b_flat,
  output logic [N*N*AW-1:0] c_flat,
  output logic            busy,
  output logic            done
);
  localparam int LAST = 3 * N - 3;
  localparam int CW   = $clog2(LAST + 1);

  logic          accept;
  logic [CW-1:0] cnt;
  logic [N*N*DW-1:0] a_q, b_q;

  logic signed [DW-1:0] a_h [N][N+1];
  logic signed [DW-1:0] b_v [N+1][N];
  logic [N*DW-1:0]      b_col [N];

  mm_ctrl #(.N(N), .CW(CW)) u_ctrl (
    .clk(clk), .rst(rst), .start(start), .accept(accept),
    .busy(busy), .done(done), .cnt(cnt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      a_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= a_flat;
      b_q <= b_flat;
    end
  end

  for (genvar e = 0; e < N; e++) begin : g_edge
    for (genvar k = 0; k < N; k++) begin : g_col_pack
      assign b_col[e][k*DW +: DW] = b_q[(k*N+e)*DW +: DW];
    end

    mm_feed #(.N(N), .DW(DW), .CW(CW), .LANE(e)) u_row_feed (
      .busy(busy), .cnt(cnt), .vec(a_q[e*N*DW +: N*DW]), .feed(a_h[e][0])
    );

    mm_feed #(.N(N), .DW(DW), .CW(CW), .LANE(e)) u_col_feed (
      .busy(busy), .cnt(cnt), .vec(b_col[e]), .feed(b_v[0][e])
    );
  end

  for (genvar i = 0; i < N; i++) begin : g_row
    for (genvar j = 0; j < N; j++) begin : g_cell
      logic signed [AW-1:0] acc;

      mm_pe #(.DW(DW), .AW(AW)) u_pe (
        .clk(clk), .rst(rst), .clr(accept), .en(busy),
        .a_in(a_h[i][j]), .b_in(b_v[i][j]),
        .a_out(a_h[i][j+1]), .b_out(b_v[i+1][j]),
        .acc(acc)
      );

      assign c_flat[(i*N+j)*AW +: AW] = acc;
    end
  end

  p_result_hold_r4: assert property (@(posedge clk) disable iff (rst)
    (done && !start) |=> $stable(c_flat));

  p_accept_idle_r6: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);
endmodule

// File: tb/systolic_mm_test.sv
module systolic_mm_test;
  localparam int N  = 3;
  localparam int DW = 8;
  localparam int AW = 18;
  localparam int CWID = N * N * AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic [N*N*DW-1:0] a_flat = '0;
  logic [N*N*DW-1:0] b_flat = '0;
  logic [CWID-1:0]   c_flat;
  logic busy, done;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  int ea [N][N];
  int eb [N][N];
  int na [N][N];
  int nb [N][N];

  systolic_mm #(.N(N), .DW(DW), .AW(AW)) uut (
    .clk(clk), .rst(rst), .start(start), .a_flat(a_flat), .b_flat(b_flat),
    .c_flat(c_flat), .busy(busy), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string req, input logic [CWID-1:0] act,
                     input logic [CWID-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [CWID-1:0] exp_flat(input int m);
    logic [CWID-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        int s;
        s = 0;
        for (int k = 0; k < N; k++) begin
          if (i + j + k + 1 <= m) s += ea[i][k] * eb[k][j];
        end
        r[(i*N+j)*AW +: AW] = s[AW-1:0];
      end
    end
    return r;
  endfunction

  function automatic int rnd8();
    return int'($urandom_range(255)) - 128;
  endfunction

  task automatic kick();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        a_flat[(i*N+j)*DW +: DW] = ea[i][j][DW-1:0];
        b_flat[(i*N+j)*DW +: DW] = eb[i][j][DW-1:0];
      end
    end
    start = 1'b1;
  endtask

  task automatic fill_rand();
    for (int i = 0; i < N; i++) begin
      for (int j = 0; j < N; j++) begin
        ea[i][j] = rnd8();
        eb[i][j] = rnd8();
      end
    end
  endtask

  // Called at a negedge with start already high; follows the product
  task automatic run(input int glitch, input bit chain);
    @(negedge clk);
    start = 1'b0;
    for (int m = 1; m <= 2 * N + 1; m++) begin
      @(negedge clk);
      start = 1'b0;
      chk("R8 partial sums", c_flat, exp_flat(m));
      chk("R3 done timing", CWID'(done), CWID'(m == 2 * N + 1));
      chk("R9 busy window", CWID'(busy), CWID'(m < 2 * N + 1));
      if (m == 2 * N + 1) chk("R2 final product", c_flat, exp_flat(3 * N));
      if (m == glitch) begin
        a_flat = {$urandom, $urandom, $urandom};
        b_flat = {$urandom, $urandom, $urandom};
        start = 1'b1;
      end
    end
    if (chain) begin
      ea = na;
      eb = nb;
      kick();
    end else begin
      for (int p = 0; p < 3; p++) begin
        @(negedge clk);
        chk("R3 done single cycle", CWID'(done), '0);
        chk("R4 results held", c_flat, exp_flat(3 * N));
        a_flat = {$urandom, $urandom, $urandom};
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL R3 watchdog: actual no finish expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4321));
    repeat (3) @(negedge clk);
    chk("R1 reset outputs", {c_flat[CWID-1:2], busy, done}, '0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after reset", {c_flat[CWID-1:2], busy, done}, '0);

    // Directed: distinct small values
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ea[i][j] = i * N + j + 1;
        eb[i][j] = 10 * (j + 1) - i;
      end
    kick();
    run(0, 1'b0);

    // R7: all most-negative entries
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ea[i][j] = -128;
        eb[i][j] = -128;
      end
    kick();
    run(0, 1'b0);
    chk("R7 no wrap 49152", c_flat[AW-1:0], CWID'(49152));

    // Mixed extremes
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        ea[i][j] = ((i + j) % 2 == 0) ? 127 : -128;
        eb[i][j] = ((i + j) % 2 == 0) ? -128 : 127;
      end
    kick();
    run(0, 1'b0);

    // R5: start and new data during a running product
    fill_rand();
    kick();
    run(3, 1'b0);

    // R6: new start in the cycle of done
    fill_rand();
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        na[i][j] = rnd8();
        nb[i][j] = rnd8();
      end
    kick();
    run(0, 1'b1);
    run(0, 1'b0);

    // Random products
    for (int t = 0; t < 20; t++) begin
      fill_rand();
      kick();
      run(0, 1'b0);
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule